// File: doc/BRIEF.md
# Programmable Near-Empty / Near-Full Level Flags

This block produces two programmable fill-level flags for a dual-clock FIFO whose storage and data paths live elsewhere. It takes the FIFO's write pointer (owned by the write clock) and read pointer (owned by the read clock), both Gray coded, and carries each across to the opposite domain through a two-stage synchronizer. The near-empty flag is evaluated in the read-clock domain against an offset X. The near-full flag is evaluated in the write-clock domain against the depth minus an offset Y.

Both flags are active low and pessimistic. An event in the flag's own domain that pushes the level toward the threshold takes effect at once, because the local pointer is used directly. An event in the far domain that moves the level away from the threshold is seen only after two edges of the flag's own clock. Offsets X and Y come from reset defaults. Afterwards they can be written as whole words or shifted in one bit per write-clock edge. Offsets are treated as static configuration: they are changed only while the FIFO is idle.

Top module: `pflag_gen`

## Requirements
- R1: The fill count is (write pointer − read pointer) modulo 2^(ADDR_W+1), where DEPTH = 2^ADDR_W. The read pointer already counts a word moved into the FIFO's output register. `near_empty_n` is 0 when the count is X or less, and 1 when it is X+1 or more.
- R2: `near_full_n` is 0 when the count is DEPTH−Y or more, and 1 when it is DEPTH−Y−1 or less.
- R3: A read-pointer step that brings the count to X or less drives `near_empty_n` to 0 with no further read-clock edge.
- R4: After a write-pointer step that raises the count from X to X+1, `near_empty_n` stays 0 through the first rising `rclk` edge. It becomes 1 on the second rising `rclk` edge after the step, and it never rises except through a change of the synchronized write pointer.
- R5: A write-pointer step that brings the count to DEPTH−Y drives `near_full_n` to 0 with no further write-clock edge. A read-pointer step that brings the count to DEPTH−Y−1 sets `near_full_n` to 1 on the second rising `wclk` edge after it.
- R6: While `rst_n` is 0, both flags are 0. A `wclk` edge with `rst_n` at 0 loads X with DEF_X and Y with DEF_Y (both 8 by default) and clears the synchronizers.
- R7: A `wclk` edge with `ofs_ld_x` at 1 loads `ofs_data` into X. A `wclk` edge with `ofs_ld_y` at 1 loads `ofs_data` into Y. A cycle with either load at 1 performs no serial shift.
- R8: With no word load and `ser_en` at 1, each `wclk` edge shifts `ser_bit` into the chain {X,Y}, most significant bit first. After 2·ADDR_W edges, X holds the first ADDR_W bits and Y holds the rest.
- R9: Pointer inputs are Gray coded, change by at most one bit per edge of their own clock, and wrap at 2^(ADDR_W+1). Both flags remain correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, held across edges of both clocks |
| wr_ptr_gray | input | ADDR_W+1 | FIFO write pointer, Gray coded, `wclk` domain |
| rd_ptr_gray | input | ADDR_W+1 | FIFO read pointer, Gray coded, `rclk` domain |
| ofs_ld_x | input | 1 | Word load of offset X |
| ofs_ld_y | input | 1 | Word load of offset Y |
| ofs_data | input | ADDR_W | Offset value for word loads |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |
| near_empty_n | output | 1 | Low when the FIFO is near empty, `rclk` domain |
| near_full_n | output | 1 | Low when the FIFO is near full, `wclk` domain |

## Verification
The bench builds the block with ADDR_W = 4, DEF_X = 3 and DEF_Y = 2. This gives a 16-word FIFO with 5-bit pointers, so a short run reaches the full threshold and carries both pointers through their wrap from 31 to 0. Default offsets below the mid-point keep the near-empty and near-full thresholds far apart, so each flag's boundary can be probed one word at a time. The two clocks share a 20 ns period with a 7 ns skew. The two-edge release latency can therefore be sampled at a fixed time between the first and second synchronizing edge.

// File: rtl/pflag_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the programmable level-flag block.
package pflag_pkg;
    // Which side of the FIFO a level flag watches.
    typedef enum logic {
        LVL_NEAR_EMPTY = 1'b0,
        LVL_NEAR_FULL  = 1'b1
    } lvl_kind_e;

    // Synchronizer length; the two-edge release latency depends on it.
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/pf_gray2bin.sv
`timescale 1ns/1ps
// pf_gray2bin: combinational Gray-to-binary conversion.
// Assumes: input is a valid reflected Gray code of width PW.
module pf_gray2bin #(
    parameter int unsigned PW = 5
) (
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    // Each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign bin_out[i] = ^gray_in[PW-1:i];
    end
endmodule

// File: rtl/pf_gray_sync.sv
`timescale 1ns/1ps
// pf_gray_sync: multi-stage synchronizer carrying a Gray pointer into the
// destination clock domain.
// Assumes: gray_in changes at most one bit per source-clock edge, so any
// sampled value is either the old or the new pointer.
module pf_gray_sync #(
    parameter int unsigned PW     = 5,
    parameter int unsigned STAGES = pflag_pkg::SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] gray_out
);
    logic [PW-1:0] chain [STAGES];

    // Shift the pointer through the stage chain; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                chain[i] <= '0;
            end
        end else begin
            chain[0] <= gray_in;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign gray_out = chain[STAGES-1];
endmodule

// File: rtl/pf_offset_regs.sv
`timescale 1ns/1ps
// pf_offset_regs: holds the near-empty offset X and near-full offset Y.
// Reset loads defaults. A word load writes either register. A serial shift
// moves ser_bit through {X,Y}, MSB first. A word load suppresses the shift.
// Assumes: offsets change only while the FIFO is idle; X is read in the
// read domain as static configuration.
module pf_offset_regs #(
    parameter int unsigned OW    = 8,
    parameter int unsigned DEF_X = 8,
    parameter int unsigned DEF_Y = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_x,
    input  logic          ld_y,
    input  logic [OW-1:0] ld_data,
    input  logic          ser_en,
    input  logic          ser_bit,
    output logic [OW-1:0] ofs_x,
    output logic [OW-1:0] ofs_y
);
    localparam logic [OW-1:0] X_RST = OW'(DEF_X);
    localparam logic [OW-1:0] Y_RST = OW'(DEF_Y);

    // Update the offsets: reset defaults, then word load, then serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ofs_x <= X_RST;
            ofs_y <= Y_RST;
        end else if (ld_x || ld_y) begin
            if (ld_x) ofs_x <= ld_data;
            if (ld_y) ofs_y <= ld_data;
        end else if (ser_en) begin
            {ofs_x, ofs_y} <= {ofs_x[OW-2:0], ofs_y, ser_bit};
        end
    end

    // R7: a word load of X lands on the next edge.
    p_word_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_x |=> (ofs_x == $past(ld_data)));

    // R8: with no load and no shift, both offsets hold.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_x && !ld_y && !ser_en) |=> ($stable(ofs_x) && $stable(ofs_y)));
endmodule

// File: rtl/pf_level_flag.sv
`timescale 1ns/1ps
// pf_level_flag: one active-low level flag in one clock domain.
// The local pointer is this domain's own pointer. The remote pointer is the
// synchronized pointer from the other domain.
// LVL_NEAR_EMPTY: fill = remote - local; flag high when fill > offset.
// LVL_NEAR_FULL : fill = local - remote; flag high when fill + offset < depth.
// Assumes: pointers only move forward and the read pointer never passes
// the write pointer.
module pf_level_flag #(
    parameter int unsigned          ADDR_W = 8,
    parameter pflag_pkg::lvl_kind_e KIND   = pflag_pkg::LVL_NEAR_EMPTY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   local_bin,
    input  logic [ADDR_W:0]   remote_bin,
    input  logic [ADDR_W-1:0] offset,
    output logic              flag_n
);
    localparam int unsigned   PW      = ADDR_W + 1;
    localparam logic [PW:0]   DEPTH_V = (PW+1)'(1) << ADDR_W;

    logic [PW-1:0] fill;
    logic          level_ok;

    if (KIND == pflag_pkg::LVL_NEAR_EMPTY) begin : g_empty
        // Words present as seen from the read side.
        assign fill     = remote_bin - local_bin;
        // Above the low threshold once fill reaches X+1.
        assign level_ok = (fill > {1'b0, offset});
    end else begin : g_full
        logic [PW:0] reach;
        // Words present as seen from the write side.
        assign fill     = local_bin - remote_bin;
        // Below the high threshold while fill + Y stays under depth.
        assign reach    = {1'b0, fill} + {2'b00, offset};
        assign level_ok = (reach < DEPTH_V);
    end

    // Force the flag low whenever reset is held.
    assign flag_n = rst_n & level_ok;

    // R4/R5: the flag rises only through a newly synchronized far pointer.
    p_rise_via_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag_n) && $past(rst_n) && $stable(offset)) |-> !$stable(remote_bin));
endmodule

// File: rtl/pflag_gen.sv
`timescale 1ns/1ps
// pflag_gen: programmable near-empty / near-full flags for a dual-clock FIFO.
// The near-empty flag lives in the rclk domain and the near-full flag in the
// wclk domain. Each far pointer reaches the flag through a two-stage Gray
// synchronizer, so a flag releases two edges of its own clock late.
// Assumes: rst_n is held low across edges of both clocks; pointer inputs
// are registered Gray codes stepping one bit at a time.
module pflag_gen #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DEF_X  = 8,
    parameter int unsigned DEF_Y  = 8
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   wr_ptr_gray,
    input  logic [ADDR_W:0]   rd_ptr_gray,
    input  logic              ofs_ld_x,
    input  logic              ofs_ld_y,
    input  logic [ADDR_W-1:0] ofs_data,
    input  logic              ser_en,
    input  logic              ser_bit,
    output logic              near_empty_n,
    output logic              near_full_n
);
    localparam int unsigned PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray_rs, rd_gray_ws;
    logic [PW-1:0]     wr_bin_rs, rd_bin_ws;
    logic [PW-1:0]     wr_bin, rd_bin;
    logic [ADDR_W-1:0] ofs_x, ofs_y;

    // Carry the write pointer into the read domain.
    pf_gray_sync #(.PW(PW)) u_wsync (
        .clk(rclk), .rst_n(rst_n), .gray_in(wr_ptr_gray), .gray_out(wr_gray_rs));

    // Carry the read pointer into the write domain.
    pf_gray_sync #(.PW(PW)) u_rsync (
        .clk(wclk), .rst_n(rst_n), .gray_in(rd_ptr_gray), .gray_out(rd_gray_ws));

    pf_gray2bin #(.PW(PW)) u_wr_conv    (.gray_in(wr_ptr_gray), .bin_out(wr_bin));
    pf_gray2bin #(.PW(PW)) u_rd_conv    (.gray_in(rd_ptr_gray), .bin_out(rd_bin));
    pf_gray2bin #(.PW(PW)) u_wr_rs_conv (.gray_in(wr_gray_rs),  .bin_out(wr_bin_rs));
    pf_gray2bin #(.PW(PW)) u_rd_ws_conv (.gray_in(rd_gray_ws),  .bin_out(rd_bin_ws));

    // Offset storage, programmed on the write clock.
    pf_offset_regs #(.OW(ADDR_W), .DEF_X(DEF_X), .DEF_Y(DEF_Y)) u_ofs (
        .clk(wclk), .rst_n(rst_n), .ld_x(ofs_ld_x), .ld_y(ofs_ld_y),
        .ld_data(ofs_data), .ser_en(ser_en), .ser_bit(ser_bit),
        .ofs_x(ofs_x), .ofs_y(ofs_y));

    // Near-empty flag, read-clock domain.
    pf_level_flag #(.ADDR_W(ADDR_W), .KIND(pflag_pkg::LVL_NEAR_EMPTY)) u_empty (
        .clk(rclk), .rst_n(rst_n), .local_bin(rd_bin), .remote_bin(wr_bin_rs),
        .offset(ofs_x), .flag_n(near_empty_n));

    // Near-full flag, write-clock domain.
    pf_level_flag #(.ADDR_W(ADDR_W), .KIND(pflag_pkg::LVL_NEAR_FULL)) u_full (
        .clk(wclk), .rst_n(rst_n), .local_bin(wr_bin), .remote_bin(rd_bin_ws),
        .offset(ofs_y), .flag_n(near_full_n));

    // R9: the write pointer steps at most one Gray bit per write edge.
    p_wr_gray_step_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wr_ptr_gray ^ $past(wr_ptr_gray)) <= 1);

    // R9: the read pointer steps at most one Gray bit per read edge.
    p_rd_gray_step_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rd_ptr_gray ^ $past(rd_ptr_gray)) <= 1);
endmodule

// File: tb/pflag_gen_bench.sv
`timescale 1ns/1ps
module pflag_gen_bench;
    localparam int unsigned AW = 4;
    localparam int unsigned PW = AW + 1;

    logic          wclk, rclk, rst_n;
    logic [PW-1:0] wr_g, rd_g;
    logic          ld_x, ld_y, ser_en, ser_bit;
    logic [AW-1:0] ld_data;
    logic          ne_n, nf_n;

    logic [PW-1:0] wp, rp;
    int            checks, fails;
    bit            done;

    pflag_gen #(.ADDR_W(AW), .DEF_X(3), .DEF_Y(2)) u_pflag_gen (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
        .wr_ptr_gray(wr_g), .rd_ptr_gray(rd_g),
        .ofs_ld_x(ld_x), .ofs_ld_y(ld_y), .ofs_data(ld_data),
        .ser_en(ser_en), .ser_bit(ser_bit),
        .near_empty_n(ne_n), .near_full_n(nf_n));

    // Vectors: {write ptr, read ptr, expected near_empty_n, expected near_full_n}
    // with X=3, Y=2, depth 16.
    localparam int NV = 15;
    localparam logic [11:0] VEC [NV] = '{
        {5'd0,  5'd0,  1'b0, 1'b1},
        {5'd3,  5'd0,  1'b0, 1'b1},
        {5'd4,  5'd0,  1'b1, 1'b1},
        {5'd13, 5'd0,  1'b1, 1'b1},
        {5'd14, 5'd0,  1'b1, 1'b0},
        {5'd16, 5'd0,  1'b1, 1'b0},
        {5'd16, 5'd6,  1'b1, 1'b1},
        {5'd20, 5'd10, 1'b1, 1'b1},
        {5'd30, 5'd27, 1'b0, 1'b1},
        {5'd2,  5'd28, 1'b1, 1'b1},
        {5'd12, 5'd28, 1'b1, 1'b0},
        {5'd13, 5'd31, 1'b1, 1'b0},
        {5'd17, 5'd4,  1'b1, 1'b1},
        {5'd21, 5'd18, 1'b0, 1'b1},
        {5'd22, 5'd18, 1'b1, 1'b1}
    };

    initial begin
        wclk = 1'b0;
        forever #10 wclk = ~wclk;
    end

    initial begin
        rclk = 1'b0;
        #7;
        forever #10 rclk = ~rclk;
    end

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // One write: pointer steps just after a wclk edge.
    task automatic wr1();
        @(posedge wclk); #1;
        wp   = wp + 1'b1;
        wr_g = to_gray(wp);
    endtask

    // One read: pointer steps just after an rclk edge.
    task automatic rd1();
        @(posedge rclk); #1;
        rp   = rp + 1'b1;
        rd_g = to_gray(rp);
    endtask

    // Walk writes, then reads, to absolute targets, then let both settle.
    task automatic go_to(input logic [PW-1:0] tw, input logic [PW-1:0] tr);
        while (wp != tw) wr1();
        while (rp != tr) rd1();
        repeat (4) @(posedge wclk);
        repeat (4) @(posedge rclk);
        @(posedge wclk); #3;
    endtask

    task automatic do_reset();
        @(posedge wclk); #1;
        rst_n = 1'b0;
        wp = '0; rp = '0;
        wr_g = '0; rd_g = '0;
        #2;
        chk("R6 near_empty_n low in reset", ne_n, 1'b0);
        chk("R6 near_full_n low in reset", nf_n, 1'b0);
        repeat (3) @(posedge wclk);
        #1 rst_n = 1'b1;
    endtask

    task automatic word_load(input logic lx, input logic ly, input logic [AW-1:0] d,
                             input logic se);
        @(posedge wclk); #1;
        ld_x = lx; ld_y = ly; ld_data = d; ser_en = se; ser_bit = 1'b1;
        @(posedge wclk); #1;
        ld_x = 1'b0; ld_y = 1'b0; ser_en = 1'b0; ser_bit = 1'b0;
    endtask

    task automatic ser_shift(input logic [2*AW-1:0] bits);
        for (int i = 2*AW-1; i >= 0; i--) begin
            @(posedge wclk); #1;
            ser_en = 1'b1; ser_bit = bits[i];
        end
        @(posedge wclk); #1;
        ser_en = 1'b0; ser_bit = 1'b0;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        checks = 0; fails = 0; done = 1'b0;
        rst_n = 1'b0;
        wp = '0; rp = '0; wr_g = '0; rd_g = '0;
        ld_x = 1'b0; ld_y = 1'b0; ld_data = '0; ser_en = 1'b0; ser_bit = 1'b0;

        // R6: reset state with pointers equal; near_full_n would be 1 if unmasked.
        repeat (3) @(posedge wclk);
        #3;
        chk("R6 near_empty_n at power-up reset", ne_n, 1'b0);
        chk("R6 near_full_n at power-up reset", nf_n, 1'b0);
        #1 rst_n = 1'b1;

        // R1/R2 (and R9 where the write pointer has wrapped): steady-state table.
        for (int k = 0; k < NV; k++) begin
            logic [PW-1:0] tw, tr;
            tw = VEC[k][11:7];
            tr = VEC[k][6:2];
            go_to(tw, tr);
            chk((tw < tr) ? "R9/R1 wrapped near_empty_n" : "R1 near_empty_n",
                ne_n, VEC[k][1]);
            chk((tw < tr) ? "R9/R2 wrapped near_full_n" : "R2 near_full_n",
                nf_n, VEC[k][0]);
        end

        // R3: count 4 -> 3 by a read drops near_empty_n before the next rclk edge.
        rd1();
        #2;
        chk("R3 read lowers near_empty_n at once", ne_n, 1'b0);

        // R4: count 3 -> 4 by a write; low after first rclk edge, high after second.
        @(posedge wclk); #1;
        wp = wp + 1'b1; wr_g = to_gray(wp);
        #19;
        chk("R4 near_empty_n still low after first rclk edge", ne_n, 1'b0);
        #10;
        chk("R4 near_empty_n high after second rclk edge", ne_n, 1'b1);

        // R5: reach count 13, then a write to 14 drops near_full_n at once.
        go_to(5'd0, 5'd19);
        chk("R5 near_full_n high at count 13", nf_n, 1'b1);
        wr1();
        #2;
        chk("R5 write lowers near_full_n at once", nf_n, 1'b0);

        // R5: a read to 13 releases near_full_n on the second wclk edge.
        @(posedge rclk); #1;
        rp = rp + 1'b1; rd_g = to_gray(rp);
        #22;
        chk("R5 near_full_n still low after first wclk edge", nf_n, 1'b0);
        #13;
        chk("R5 near_full_n high after second wclk edge", nf_n, 1'b1);

        // R6: change X, reset mid-run, confirm flags low and defaults restored.
        word_load(1'b1, 1'b0, 4'd9, 1'b0);
        do_reset();
        go_to(5'd4, 5'd0);
        chk("R6 default X restored (count 4)", ne_n, 1'b1);
        go_to(5'd14, 5'd0);
        chk("R6 default Y restored (count 14)", nf_n, 1'b0);

        // R7: Y=6 then X=5 with ser_en also high; the load must win, no shift.
        word_load(1'b0, 1'b1, 4'd6, 1'b0);
        word_load(1'b1, 1'b0, 4'd5, 1'b1);
        go_to(5'd14, 5'd8);
        chk("R7 X=5 near_empty_n at count 6", ne_n, 1'b1);
        chk("R7 Y=6 near_full_n at count 6", nf_n, 1'b1);
        go_to(5'd14, 5'd9);
        chk("R7 X=5 near_empty_n at count 5", ne_n, 1'b0);
        go_to(5'd19, 5'd9);
        chk("R7 Y=6 unshifted near_full_n at count 10", nf_n, 1'b0);
        go_to(5'd19, 5'd10);
        chk("R7 Y=6 near_full_n at count 9", nf_n, 1'b1);

        // R8: serial load X=1, Y=4 (bits 0001 then 0100, MSB first).
        ser_shift(8'b0001_0100);
        go_to(5'd19, 5'd17);
        chk("R8 serial X=1 near_empty_n at count 2", ne_n, 1'b1);
        go_to(5'd19, 5'd18);
        chk("R8 serial X=1 near_empty_n at count 1", ne_n, 1'b0);
        go_to(5'd29, 5'd18);
        chk("R8 serial Y=4 near_full_n at count 11", nf_n, 1'b1);
        go_to(5'd30, 5'd18);
        chk("R8 serial Y=4 near_full_n at count 12", nf_n, 1'b0);

        finish_run();
    end
endmodule